// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns bus cycles into active-low chip selects for four independently programmed channels. Each channel holds a base address, an address mask, an address-space code with its own ignore mask, and a set of control bits. The bus master offers a cycle (address, 4-bit function code, direction) on a valid/ready handshake. The decoder compares that cycle against every channel, picks the winning channel, drives its select for the length of the access and ends the access with an internal acknowledge. A write into a write-protected range gets a bus error and no select.

The handshake has simple back-pressure rules. `cyc_ready` is high whenever no access is in progress. A cycle is taken on a clock edge where `cyc_valid` and `cyc_ready` are both high. While a select is active, `cyc_ready` stays low and the offered cycle waits. A cycle that matches no channel, or that ends in a bus error, is absorbed at once and leaves `cyc_ready` high.

Channels are programmed through a 16-bit register-write port. Each channel has four halfword slots, addressed by `reg_idx = {channel, slot}`.

Top module: `addr_cs_decode`

## Requirements
- R1: A write with `reg_we` high updates the slot `reg_idx[1:0]` of channel `reg_idx[3:2]`. The slots are:
  - Slot 0: base address bits 31:16.
  - Slot 1: bits 15:8 hold base address bits 15:8, bits 7:4 the code value, bit 3 write-protect, bit 2 fast, bit 1 no-CPU-space, bit 0 valid.
  - Slot 2: mask bits 31:16.
  - Slot 3: bits 15:8 hold mask bits 15:8, bits 7:4 the code-ignore mask, bits 1:0 the delay.

  A new value applies to every cycle taken after the write edge.
- R2: Address bits 31:8 of a cycle are compared with the channel base only where the matching mask bit is 1. Address bits 7:0 never take part. The base must be aligned to the block size that the mask sets.
- R3: The cycle's function code must equal the channel's code value in every bit whose code-ignore bit is 0. A 1 in the code-ignore mask lets that bit take either value.
- R4: A cycle whose function code bits 2:0 are all ones is CPU space. It never selects a channel whose no-CPU-space bit is 1.
- R5: A channel matches only while its valid bit is 1. Reset clears the valid and no-CPU-space bits of every channel. All other fields keep their contents through reset.
- R6: When several channels match, only the lowest-numbered one is selected. At most one `cs_n` bit is low at any time.
- R7: If the winning channel has write-protect set and the cycle is a write, `bus_err` is high for exactly the one clock after the accepting edge, and no select or acknowledge follows. A read of the same range is selected normally.
- R8: With fast set, the select is low for exactly 2 clocks and `int_ack` is high in the second. The delay field has no effect.
- R9: With fast clear, the select is low for 3 + delay clocks (3 to 6) and `int_ack` is high in the last. The select stays unchanged until the access ends.
- R10: A cycle that matches no channel produces no select, no `int_ack` and no `bus_err`.
- R11: `cyc_ready` is high after reset and whenever no select is active, and low while one is. The select goes low in the clock after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | {channel, slot} of the written halfword |
| reg_wdata | input | 16 | Halfword to write |
| cyc_valid | input | 1 | A bus cycle is offered |
| cyc_ready | output | 1 | Decoder can take a cycle |
| cyc_addr | input | 32 | Cycle address |
| cyc_fc | input | 4 | Cycle function code (address-space type) |
| cyc_write | input | 1 | 1 = write cycle, 0 = read |
| cs_n | output | 4 | Active-low chip selects, one per channel |
| int_ack | output | 1 | Internal acknowledge, last clock of an access |
| bus_err | output | 1 | Write-protect violation pulse |

## Verification
On every cycle the assertions check the following port-level rules:
- At most one select is active, and `cyc_ready` is low while a select is active.
- The select is held steady until the acknowledge, and is released right after it.
- No acknowledge appears in the first clock of an access.
- A bus error only follows an accepted write and never comes with a select.

Only the bench's scenarios can show which channel should win for a given address, code and configuration, and the exact access length for fast and delayed channels. The same holds for the effect of the no-CPU-space and valid bits, and for which fields survive reset. The bench checks these with a sweep of codes, addresses and directions against a model computed from the programmed fields.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int ADDR_W   = 32;
  localparam int HALF_W   = 16;
  localparam int PAGE_LSB = 8;
  localparam int CMP_W    = ADDR_W - PAGE_LSB;
  localparam int LOW_W    = CMP_W - HALF_W;
  localparam int FC_W     = 4;
  localparam int DLY_W    = 2;
  localparam int FAST_LEN = 2;
  localparam int BASE_LEN = 3;
  localparam int MAX_LEN  = BASE_LEN + (1 << DLY_W) - 1;
  localparam int LEN_W    = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {
    SLOT_BASE_HI = 2'd0,
    SLOT_BASE_LO = 2'd1,
    SLOT_MASK_HI = 2'd2,
    SLOT_MASK_LO = 2'd3
  } slot_e;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [FC_W-1:0]  fc_val;
    logic             wprot;
    logic             fast;
    logic             no_cpu;
    logic             valid;
    logic [CMP_W-1:0] amask;
    logic [FC_W-1:0]  fc_ign;
    logic [DLY_W-1:0] dly;
  } chan_cfg_t;
endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH),
  localparam int IDX_W = CH_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [HALF_W-1:0]       wdata,
  output chan_cfg_t [N_CH-1:0]    cfg
);
  slot_e slot;
  assign slot = slot_e'(idx[1:0]);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic             sel_w;
    logic [CMP_W-1:0] base_q, amask_q;
    logic [FC_W-1:0]  fcv_q, fci_q;
    logic             wp_q, fast_q, nocpu_q, valid_q;
    logic [DLY_W-1:0] dly_q;

    assign sel_w = we && (idx[IDX_W-1:2] == CH_W'(c));

    // Fields left untouched by reset
    always_ff @(posedge clk) begin
      if (sel_w) begin
        case (slot)
          SLOT_BASE_HI: base_q[CMP_W-1 -: HALF_W] <= wdata;
          SLOT_BASE_LO: begin
            base_q[LOW_W-1:0] <= wdata[HALF_W-1 -: LOW_W];
            fcv_q             <= wdata[FC_W+3:4];
            wp_q              <= wdata[3];
            fast_q            <= wdata[2];
          end
          SLOT_MASK_HI: amask_q[CMP_W-1 -: HALF_W] <= wdata;
          SLOT_MASK_LO: begin
            amask_q[LOW_W-1:0] <= wdata[HALF_W-1 -: LOW_W];
            fci_q              <= wdata[FC_W+3:4];
            dly_q              <= wdata[DLY_W-1:0];
          end
          default: ;
        endcase
      end
    end

    // Enable bits cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nocpu_q <= 1'b0;
        valid_q <= 1'b0;
      end else if (sel_w && slot == SLOT_BASE_LO) begin
        nocpu_q <= wdata[1];
        valid_q <= wdata[0];
      end
    end

    assign cfg[c] = '{base: base_q, fc_val: fcv_q, wprot: wp_q, fast: fast_q,
                      no_cpu: nocpu_q, valid: valid_q, amask: amask_q,
                      fc_ign: fci_q, dly: dly_q};
  end
endmodule

// File: rtl/csd_decode.sv
module csd_decode
  import csd_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  chan_cfg_t [N_CH-1:0] cfg,
  input  logic [CMP_W-1:0]     page,
  input  logic [FC_W-1:0]      fc,
  output logic                 any,
  output logic [N_CH-1:0]      grant,
  output logic                 win_wp,
  output logic                 win_fast,
  output logic [DLY_W-1:0]     win_dly
);
  logic            cpu_space;
  logic [N_CH-1:0] hit;
  logic [CH_W-1:0] win_idx;

  assign cpu_space = &fc[2:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_cmp
    logic addr_ok, fc_ok, space_ok;
    assign addr_ok  = ((page ^ cfg[c].base) & cfg[c].amask) == '0;
    assign fc_ok    = ((fc ^ cfg[c].fc_val) & ~cfg[c].fc_ign) == '0;
    assign space_ok = !(cfg[c].no_cpu && cpu_space);
    assign hit[c]   = cfg[c].valid && addr_ok && fc_ok && space_ok;
  end

  // Lowest-numbered match wins
  assign any   = |hit;
  assign grant = hit & (~hit + N_CH'(1));

  always_comb begin
    win_idx = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (hit[c]) win_idx = CH_W'(c);
    end
  end

  assign win_wp   = cfg[win_idx].wprot;
  assign win_fast = cfg[win_idx].fast;
  assign win_dly  = cfg[win_idx].dly;
endmodule

// File: rtl/csd_seq.sv
module csd_seq
  import csd_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic             cyc_write,
  input  logic             any,
  input  logic [N_CH-1:0]  grant,
  input  logic             win_wp,
  input  logic             win_fast,
  input  logic [DLY_W-1:0] win_dly,
  output logic             cyc_ready,
  output logic [N_CH-1:0]  cs_n,
  output logic             int_ack,
  output logic             bus_err
);
  logic             busy_q, berr_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [N_CH-1:0]  sel_q;
  logic             accept, blocked, start;

  assign cyc_ready = !busy_q;
  assign accept    = cyc_valid && !busy_q;
  assign blocked   = any && win_wp && cyc_write;
  assign start     = accept && any && !blocked;

  assign int_ack = busy_q && (cnt_q == len_q);
  assign cs_n    = ~(sel_q & {N_CH{busy_q}});
  assign bus_err = berr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      berr_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      sel_q  <= '0;
    end else begin
      berr_q <= accept && blocked;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= LEN_W'(1);
        len_q  <= win_fast ? LEN_W'(FAST_LEN) : LEN_W'(BASE_LEN) + LEN_W'(win_dly);
        sel_q  <= grant;
      end else if (int_ack) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/addr_cs_decode.sv
module addr_cs_decode
  import csd_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int IDX_W = $clog2(N_CH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [FC_W-1:0]   cyc_fc,
  input  logic              cyc_write,
  output logic [N_CH-1:0]   cs_n,
  output logic              int_ack,
  output logic              bus_err
);
  chan_cfg_t [N_CH-1:0] cfg;
  logic                 any, win_wp, win_fast;
  logic [N_CH-1:0]      grant;
  logic [DLY_W-1:0]     win_dly;
  logic                 unused_lo;

  assign unused_lo = ^cyc_addr[PAGE_LSB-1:0];

  csd_regs #(.N_CH(N_CH)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
    .wdata(reg_wdata), .cfg(cfg)
  );

  csd_decode #(.N_CH(N_CH)) dec_i (
    .cfg(cfg), .page(cyc_addr[ADDR_W-1:PAGE_LSB]), .fc(cyc_fc),
    .any(any), .grant(grant), .win_wp(win_wp), .win_fast(win_fast),
    .win_dly(win_dly)
  );

  csd_seq #(.N_CH(N_CH)) seq_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .any(any), .grant(grant), .win_wp(win_wp), .win_fast(win_fast),
    .win_dly(win_dly), .cyc_ready(cyc_ready), .cs_n(cs_n),
    .int_ack(int_ack), .bus_err(bus_err)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_valid,
  input logic            cyc_ready,
  input logic            cyc_write,
  input logic [N_CH-1:0] cs_n,
  input logic            int_ack,
  input logic            bus_err
);
  logic sel_on;
  assign sel_on = (cs_n != '1);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_on |-> !cyc_ready); // R11
  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> sel_on); // R10
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !sel_on); // R8
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_on && !int_ack) |=> (cs_n == $past(cs_n))); // R9
  AST_NO_FIRST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_on && ($past(cs_n) == '1)) |-> !int_ack); // R8
  AST_BERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(cyc_valid && cyc_ready && cyc_write)); // R7
  AST_BERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !sel_on); // R7
endmodule

bind addr_cs_decode csd_checker #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
  .cyc_write(cyc_write), .cs_n(cs_n), .int_ack(int_ack), .bus_err(bus_err)
);

// File: tb/addr_cs_decode_tb_top.sv
module addr_cs_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic        cyc_valid = 1'b0;
  logic        cyc_ready;
  logic [31:0] cyc_addr = '0;
  logic [3:0]  cyc_fc = '0;
  logic        cyc_write = 1'b0;
  logic [3:0]  cs_n;
  logic        int_ack, bus_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [23:0] sh_base [4];
  logic [23:0] sh_mask [4];
  logic [3:0]  sh_fc [4];
  logic [3:0]  sh_fci [4];
  logic [1:0]  sh_dly [4];
  bit          sh_wp [4];
  bit          sh_fast [4];
  bit          sh_nocpu [4];
  bit          sh_valid [4];

  always #10 clk = ~clk;

  addr_cs_decode dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_addr(cyc_addr), .cyc_fc(cyc_fc), .cyc_write(cyc_write),
    .cs_n(cs_n), .int_ack(int_ack), .bus_err(bus_err)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic wr_reg(input int ch, input int slot, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_idx = {ch[1:0], slot[1:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (slot)
      0: sh_base[ch][23:8] = d;
      1: begin
        sh_base[ch][7:0] = d[15:8];
        sh_fc[ch] = d[7:4];
        sh_wp[ch] = d[3];
        sh_fast[ch] = d[2];
        sh_nocpu[ch] = d[1];
        sh_valid[ch] = d[0];
      end
      2: sh_mask[ch][23:8] = d;
      default: begin
        sh_mask[ch][7:0] = d[15:8];
        sh_fci[ch] = d[7:4];
        sh_dly[ch] = d[1:0];
      end
    endcase
  endtask

  function automatic void model(input logic [31:0] a, input logic [3:0] f, input bit w,
                                output int ch, output int len, output bit be);
    ch = -1;
    len = 0;
    be = 1'b0;
    for (int c = 3; c >= 0; c--) begin
      if (sh_valid[c] && (((a[31:8] ^ sh_base[c]) & sh_mask[c]) == 24'd0) &&
          (((f ^ sh_fc[c]) & ~sh_fci[c]) == 4'd0) &&
          !(sh_nocpu[c] && f[2:0] == 3'b111))
        ch = c;
    end
    if (ch >= 0) begin
      if (sh_wp[ch] && w) begin
        be = 1'b1;
        ch = -1;
      end else begin
        len = sh_fast[ch] ? 2 : 3 + int'(sh_dly[ch]);
      end
    end
  endfunction

  task automatic xact(input string tag, input logic [31:0] a, input logic [3:0] f, input bit w);
    int exp_ch, exp_len, got_ch, got_len, ack_pos, exp_ack;
    bit exp_be, got_be, bad;
    model(a, f, w, exp_ch, exp_len, exp_be);
    bad = 1'b0;
    @(negedge clk);
    if (!cyc_ready) bad = 1'b1;
    cyc_valid = 1'b1;
    cyc_addr = a;
    cyc_fc = f;
    cyc_write = w;
    @(negedge clk);
    cyc_valid = 1'b0;
    got_ch = -1;
    got_len = 0;
    ack_pos = 0;
    got_be = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (bus_err) got_be = 1'b1;
      if (cs_n != 4'hF) begin
        got_len++;
        if (cyc_ready) bad = 1'b1;
        for (int c = 0; c < 4; c++) begin
          if (!cs_n[c]) begin
            if (got_ch < 0) got_ch = c;
            else if (got_ch != c) bad = 1'b1;
          end
        end
        if (int_ack) ack_pos = got_len;
      end else if (int_ack) begin
        bad = 1'b1;
      end
      if (k < 9) @(negedge clk);
    end
    exp_ack = (exp_ch >= 0) ? exp_len : 0;
    checks++;
    if (got_ch != exp_ch || got_len != exp_len || ack_pos != exp_ack ||
        got_be != exp_be || bad) begin
      errors++;
      $display("FAIL %s a=%h fc=%0d w=%0d: actual ch=%0d len=%0d ack=%0d berr=%0d bad=%0d expected ch=%0d len=%0d ack=%0d berr=%0d bad=0",
               tag, a, f, w, got_ch, got_len, ack_pos, got_be, bad,
               exp_ch, exp_len, exp_ack, exp_be);
    end
  endtask

  task automatic idle_check(input string tag);
    checks++;
    if (cs_n != 4'hF || int_ack || bus_err || !cyc_ready) begin
      errors++;
      $display("FAIL %s idle outputs: actual cs_n=%h ack=%0d berr=%0d ready=%0d expected cs_n=f ack=0 berr=0 ready=1",
               tag, cs_n, int_ack, bus_err, cyc_ready);
    end
  endtask

  initial begin
    logic [31:0] sweep_addr [8];
    sweep_addr = '{32'h0010_0000, 32'h0010_00FF, 32'h0010_0100, 32'h001F_FFFF,
                   32'h0020_0000, 32'h0020_FFFF, 32'h0030_0000, 32'hFFFF_FF00};
    for (int c = 0; c < 4; c++) begin
      sh_valid[c] = 1'b0;
      sh_nocpu[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R11 reset");

    // R1: program all four channels through the write port
    wr_reg(0, 0, 16'h0010); wr_reg(0, 1, 16'h0055);
    wr_reg(0, 2, 16'hFFF0); wr_reg(0, 3, 16'h0000);
    wr_reg(1, 0, 16'h0020); wr_reg(1, 1, 16'h001B);
    wr_reg(1, 2, 16'hFFFF); wr_reg(1, 3, 16'h0062);
    wr_reg(2, 0, 16'h0010); wr_reg(2, 1, 16'h0001);
    wr_reg(2, 2, 16'hFFFF); wr_reg(2, 3, 16'hFFF0);
    wr_reg(3, 0, 16'h8000); wr_reg(3, 1, 16'h0000);
    wr_reg(3, 2, 16'h8000); wr_reg(3, 3, 16'h00F3);

    xact("R2", 32'h0020_FFFC, 4'd1, 1'b0);
    xact("R2", 32'h0021_0000, 4'd1, 1'b0);
    xact("R3", 32'h0020_0000, 4'd3, 1'b0);
    xact("R3", 32'h0020_0000, 4'd9, 1'b0);
    xact("R4", 32'h0020_0000, 4'd7, 1'b0);
    xact("R4", 32'h0010_0004, 4'd7, 1'b0);
    xact("R6", 32'h0010_0010, 4'd5, 1'b0);
    xact("R6", 32'h0010_0010, 4'd6, 1'b0);
    xact("R7", 32'h0020_0100, 4'd1, 1'b1);
    xact("R7", 32'h0020_0100, 4'd1, 1'b0);
    xact("R8", 32'h001F_0000, 4'd5, 1'b0);
    xact("R8", 32'h001F_0000, 4'd5, 1'b1);
    xact("R9", 32'h0010_00F0, 4'd2, 1'b0);
    xact("R10", 32'h4000_0000, 4'd5, 1'b0);
    xact("R5", 32'h9000_0000, 4'd1, 1'b0);
    wr_reg(3, 1, 16'h0001);
    xact("R5", 32'h9000_0000, 4'd1, 1'b0);
    xact("R9", 32'hF000_0000, 4'd7, 1'b1);
    wr_reg(2, 3, 16'hFFF1);
    xact("R1", 32'h0010_0020, 4'd0, 1'b0);

    // Sweep of codes, addresses and directions
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 8; i++)
        for (int w = 0; w < 2; w++)
          xact("R3", sweep_addr[i], 4'(f), w[0]);

    // R5: reset clears enables but keeps the other fields
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      sh_valid[c] = 1'b0;
      sh_nocpu[c] = 1'b0;
    end
    @(negedge clk);
    idle_check("R5 reset");
    xact("R5", 32'h0020_0000, 4'd1, 1'b0);
    xact("R5", 32'h0010_0000, 4'd5, 1'b0);
    wr_reg(1, 1, 16'h001B);
    xact("R5", 32'h0020_0040, 4'd1, 1'b0);
    xact("R5", 32'h0020_0040, 4'd1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule